// File: doc/BRIEF.md
# Audio Word Byte Reorder Stage

This stage sits in the DMA data path between a host-side sample buffer and a serial codec port. Each accepted audio word occupies a slot of one to four bytes and arrives little-endian, with its least significant byte in the lowest byte lane. When the global swap enable is set, the stage emits the word big-endian within its slot. One enable governs both transfer directions, so the playback and record streams are reordered alike.

Some samples are one nibble narrower than their slot, for example 20 data bits in a 3-byte slot. In that case the stage also exchanges the two nibbles of the byte that was most significant. After reversal that byte lands in the lowest lane. The data bits then run without a gap from the top of the slot, and the pad nibble ends up at the bottom.

The word, the slot length code, the data bit count and the enable are all captured together on a valid/ready handshake. The result leaves from a single output register one cycle later. Back-pressure on the output stalls the input.

Top module: `audio_byte_swapper`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R2: With swap_en = 0, an accepted word leaves unchanged within its slot, except that lanes above the slot are zeroed (R6).
- R3: With swap_en = 1 and slot_bits = 8·L (L = slot_code + 1 bytes; code 0..3 selects 1..4 bytes), output lane L-1-i holds input lane i, where lane 0 is bits 7:0.
- R4: With swap_en = 1 and slot_bits = 8·L − 4, the lanes are reversed as in R3, and output lane 0 then holds input lane L-1 with its upper and lower nibbles exchanged. For 20 bits in 3 bytes, 0x0ABCDE becomes 0xDEBCA0.
- R5: With swap_en = 1 and any other slot_bits value, plain lane reversal as in R3 is applied with no nibble exchange.
- R6: In both modes, output lanes at or above L are zero.
- R7: A word is captured only when in_valid and in_ready are both 1. in_ready is 0 whenever out_valid is 1 and out_ready is 0.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_data hold steady, whatever the inputs and configuration do.
- R9: A word captured at one clock edge is presented on out_valid/out_data after that edge, one cycle of latency in both modes. A word held while the input is idle leaves at the edge where out_ready is 1, and out_valid then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_en | input | 1 | Global byte-reversal enable, applies to both directions |
| slot_code | input | 2 | Slot length in bytes minus one |
| slot_bits | input | 6 | Data bits carried per slot |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept a word |
| in_data | input | 32 | Little-endian input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Reordered output word |

## Verification
A held word can be released and its successor captured at the same clock edge. The successor may also carry a different slot length, bit count and enable. The bench provokes this overlap by stalling a word with out_ready low while a second word with a different configuration waits on the input. It then raises out_ready for one edge. The held output must not change during the stall, and after that edge the second word must appear, reordered under its own configuration, with out_valid still high and no bubble.

// File: rtl/audio_byte_swapper_pkg.sv
package audio_byte_swapper_pkg;

  // exchange the two nibbles of a byte
  function automatic logic [7:0] nib_xchg(input logic [7:0] b);
    return {b[3:0], b[7:4]};
  endfunction

  // slot configuration captured with each word
  typedef struct packed {
    logic       en;
    logic [1:0] code;
    logic [5:0] bits;
  } slot_cfg_t;

endpackage

// File: rtl/abs_lane_mask.sv
module abs_lane_mask #(
  parameter int BYTES  = 4,
  parameter int CODE_W = 2,
  localparam int W     = 8 * BYTES
) (
  input  logic [W-1:0]      din,
  input  logic [CODE_W-1:0] code,
  output logic [W-1:0]      dout
);
  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    assign dout[j*8 +: 8] = (j <= int'(code)) ? din[j*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/abs_reorder.sv
module abs_reorder
  import audio_byte_swapper_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int CODE_W = 2,
  parameter int BITS_W = 6,
  localparam int W     = 8 * BYTES
) (
  input  logic [W-1:0]      din,
  input  logic [CODE_W-1:0] code,
  input  logic [BITS_W-1:0] bits,
  input  logic              en,
  output logic [W-1:0]      dout
);
  logic [W-1:0] rev;
  int           len;
  logic         short_nib;

  always_comb begin
    len       = int'(code) + 1;
    short_nib = (int'(bits) == 8 * len - 4);
    rev       = '0;
    for (int j = 0; j < BYTES; j++) begin
      if (j < len) rev[j*8 +: 8] = din[(len-1-j)*8 +: 8];
    end
    if (short_nib) rev[7:0] = nib_xchg(rev[7:0]);
    dout = en ? rev : din;
  end
endmodule

// File: rtl/abs_out_stage.sv
module abs_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end
endmodule

// File: rtl/audio_byte_swapper.sv
module audio_byte_swapper
  import audio_byte_swapper_pkg::*;
#(
  parameter int BYTES  = 4,
  localparam int W      = 8 * BYTES,
  localparam int CODE_W = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int BITS_W = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              swap_en,
  input  logic [CODE_W-1:0] slot_code,
  input  logic [BITS_W-1:0] slot_bits,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_data
);
  logic [W-1:0] masked;
  logic [W-1:0] ordered;

  abs_lane_mask #(.BYTES(BYTES), .CODE_W(CODE_W)) u_mask (
    .din (in_data),
    .code(slot_code),
    .dout(masked)
  );

  abs_reorder #(.BYTES(BYTES), .CODE_W(CODE_W), .BITS_W(BITS_W)) u_order (
    .din (masked),
    .code(slot_code),
    .bits(slot_bits),
    .en  (swap_en),
    .dout(ordered)
  );

  abs_out_stage #(.W(W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (ordered),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );
endmodule

// File: rtl/audio_byte_swapper_chk.sv
module audio_byte_swapper_chk #(
  parameter int BYTES  = 4,
  localparam int W      = 8 * BYTES,
  localparam int CODE_W = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int BITS_W = $clog2(W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              swap_en,
  input logic [CODE_W-1:0] slot_code,
  input logic [BITS_W-1:0] slot_bits,
  input logic              in_valid,
  input logic              in_ready,
  input logic [W-1:0]      in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_data
);
  logic [CODE_W-1:0] h_code;
  logic [BITS_W-1:0] h_bits;
  logic              h_en;
  logic [W-1:0]      h_data;
  logic [W-1:0]      keep;
  logic [3:0]        top_hi;
  logic              h_short;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_code <= '0; h_bits <= '0; h_en <= 1'b0; h_data <= '0;
    end else if (in_valid && in_ready) begin
      h_code <= slot_code; h_bits <= slot_bits; h_en <= swap_en; h_data <= in_data;
    end
  end

  always_comb begin
    keep = '0;
    for (int j = 0; j < BYTES; j++)
      if (j <= int'(h_code)) keep[j*8 +: 8] = 8'hFF;
    top_hi  = h_data[int'(h_code)*8 + 4 +: 4];
    h_short = h_en && (int'(h_bits) == 8 * (int'(h_code) + 1) - 4);
  end

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R9
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R9
  AST_ZERO_ABOVE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data & ~keep) == '0)); // R6
  AST_NIBBLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (out_valid && h_short) |-> (out_data[3:0] == top_hi)); // R4
endmodule

bind audio_byte_swapper audio_byte_swapper_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst(rst), .swap_en(swap_en), .slot_code(slot_code),
  .slot_bits(slot_bits), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/tb_audio_byte_swapper.sv
module tb_audio_byte_swapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        swap_en;
  logic [1:0]  slot_code;
  logic [5:0]  slot_bits;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_byte_swapper dut (
    .clk(clk), .rst(rst), .swap_en(swap_en), .slot_code(slot_code),
    .slot_bits(slot_bits), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected result built from the requirements, byte by byte
  function automatic logic [31:0] expect_word(input logic [31:0] w, input logic [1:0] code,
                                              input logic [5:0] bits, input logic en);
    int L = int'(code) + 1;
    logic [7:0] b [4];
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) b[i] = (i < L) ? w[i*8 +: 8] : 8'h00;
    if (!en) begin
      for (int i = 0; i < 4; i++) r[i*8 +: 8] = b[i];
    end else begin
      for (int i = 0; i < L; i++) r[(L-1-i)*8 +: 8] = b[i];
      if (int'(bits) == 8*L - 4) r[7:0] = {b[L-1][3:0], b[L-1][7:4]};
    end
    return r;
  endfunction

  task automatic drive(input logic [31:0] w, input logic [1:0] code,
                       input logic [5:0] bits, input logic en);
    in_data = w; slot_code = code; slot_bits = bits; swap_en = en; in_valid = 1'b1;
  endtask

  // one word through an unstalled stage
  task automatic t_single(input string req, input logic [31:0] w, input logic [1:0] code,
                          input logic [5:0] bits, input logic en, input logic [31:0] exp);
    @(negedge clk);
    drive(w, code, bits, en);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 32'hDEAD_BEEF;
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk(req, out_data, exp);
    chk({req, " model"}, exp, expect_word(w, code, bits, en));
    @(negedge clk);
    chk({req, " drained R9"}, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    swap_en = 1'b0; slot_code = '0; slot_bits = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_stall_overlap;
    logic [31:0] ea, eb;
    ea = expect_word(32'h0012_3456, 2'd2, 6'd20, 1'b1);
    eb = expect_word(32'hCAFE_F00D, 2'd3, 6'd32, 1'b1);
    @(negedge clk);
    drive(32'h0012_3456, 2'd2, 6'd20, 1'b1);
    out_ready = 1'b0;
    @(negedge clk);
    chk("R9 stalled word shown", out_data, ea);
    chk("R7 in_ready low", {31'd0, in_ready}, 32'd0);
    drive(32'hCAFE_F00D, 2'd3, 6'd32, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 held data", out_data, ea);
      chk("R8 held valid", {31'd0, out_valid}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 overlap valid", {31'd0, out_valid}, 32'd1);
    chk("R7 overlap second word", out_data, eb);
    @(negedge clk);
    chk("R9 drain after overlap", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_stream;
    logic [31:0] w [3];
    w[0] = 32'h1122_3344; w[1] = 32'h5566_7788; w[2] = 32'h99AA_BBCC;
    out_ready = 1'b1;
    @(negedge clk);
    drive(w[0], 2'd3, 6'd32, 1'b1);
    for (int k = 1; k < 3; k++) begin
      @(negedge clk);
      chk("R9 stream", out_data, expect_word(w[k-1], 2'd3, 6'd32, 1'b1));
      drive(w[k], 2'd3, 6'd32, 1'b1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 stream last", out_data, expect_word(w[2], 2'd3, 6'd32, 1'b1));
    @(negedge clk);
    chk("R9 stream drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_single("R2 pass 4B",        32'h1234_5678, 2'd3, 6'd32, 1'b0, 32'h1234_5678);
    t_single("R2 R6 pass 2B",     32'hAABB_1234, 2'd1, 6'd16, 1'b0, 32'h0000_1234);
    t_single("R3 rev 4B",         32'h1234_5678, 2'd3, 6'd32, 1'b1, 32'h7856_3412);
    t_single("R3 rev 3B",         32'h000A_BCDE, 2'd2, 6'd24, 1'b1, 32'h00DE_BC0A);
    t_single("R4 20in3",          32'h000A_BCDE, 2'd2, 6'd20, 1'b1, 32'h00DE_BCA0);
    t_single("R4 12in2",          32'h0000_0123, 2'd1, 6'd12, 1'b1, 32'h0000_2310);
    t_single("R4 R6 4in1",        32'hFFFF_FF5A, 2'd0, 6'd4,  1'b1, 32'h0000_00A5);
    t_single("R5 16in3",          32'h000A_BCDE, 2'd2, 6'd16, 1'b1, 32'h00DE_BC0A);
    t_single("R4 28in4",          32'h0123_4567, 2'd3, 6'd28, 1'b1, 32'h6745_2310);
    t_single("R6 rev 3B garbage", 32'hEE0A_BCDE, 2'd2, 6'd24, 1'b1, 32'h00DE_BC0A);
    t_stall_overlap();
    t_stream();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule